// File: doc/BRIEF.md
# FP Operand NaN Screen and Writeback Gate

This block wraps the execute stage of a floating-point unit and decides what reaches the destination register and the floating-point control/status register (FCSR). The arithmetic is done elsewhere. An operation is handed over in one cycle: its format, up to `NUM_SRC` source operands with a mask of the sources it actually uses, the result computed by the arithmetic, the FP-enable bit and the current FCSR. The block registers them and runs a short state machine.

The states are `ST_IDLE`, `ST_SCREEN`, `ST_RESCHK`, `ST_WRITE`, `ST_FAULT` and `ST_BADW`. The transitions are:

- `ST_IDLE` to `ST_FAULT` on an accepted operation while the unit is disabled.
- `ST_IDLE` to `ST_BADW` on an accepted operation with an illegal format.
- `ST_IDLE` to `ST_SCREEN` on any other accepted operation.
- `ST_SCREEN` to `ST_WRITE` when a used source is NaN.
- `ST_SCREEN` to `ST_RESCHK` otherwise.
- `ST_RESCHK` to `ST_WRITE` always.
- `ST_WRITE`, `ST_FAULT` and `ST_BADW` back to `ST_IDLE`.

When an operation is accepted, the exception cause field of the FCSR is cleared. A NaN source replaces the result. A signalling NaN becomes the default quiet NaN, and a quiet NaN is forwarded unchanged. A NaN computed result is forced to the default quiet NaN and raises the invalid-operation indication.

Top module: `fpnan_wb_gate`

## Requirements
- R1: After reset, `op_ready` is 1 and `wb_en`, `cu_fault`, `fmt_err`, `dst_value` and `fcsr_out` are 0. An operation is accepted only when `op_valid` and `op_ready` are both high. `op_ready` is low in every cycle after acceptance until the operation completes, and `op_valid` is ignored in those cycles.
- R2: From the cycle after acceptance, `fcsr_out` equals `fcsr_in` with bits 17..12 (cause field) cleared. Bits 31..18 and 11..0 are kept.
- R3: `op_fmt` = 2'b00 selects single precision, using the low 32 bits of each operand. `op_fmt` = 2'b01 selects double precision, using all 64 bits. A value is NaN when its exponent is all ones and its fraction is nonzero. A fraction MSB of 1 (bit 22 single, bit 51 double) marks a signalling NaN, and 0 marks a quiet NaN.
- R4: If the first NaN among the used sources is signalling, `dst_value` is the default quiet NaN: 64'h0000_0000_7FBF_FFFF for single, 64'h7FF7_FFFF_FFFF_FFFF for double.
- R5: If the first NaN among the used sources is quiet, it is forwarded unchanged. In single format its low 32 bits are forwarded, zero-extended.
- R6: Sources are screened in index order, so source 0 wins over source 1. A source whose `src_used` bit is 0 is ignored even if it holds a NaN.
- R7: If no used source is NaN and the computed result is NaN, `dst_value` is the default quiet NaN, and FCSR bit 16 (invalid cause) and bit 6 (invalid flag) are set.
- R8: If neither a used source nor the result is NaN, `dst_value` is the result, zero-extended in single format, and `fcsr_out` keeps its cleared value.
- R9: If `fp_enable` is 0 at acceptance, `cu_fault` pulses for one cycle with `cu_unit` = 1, and `wb_en` stays low.
- R10: If `fp_enable` is 1 and `op_fmt` is 2'b10 or 2'b11, `fmt_err` pulses for one cycle and `wb_en` stays low.
- R11: Take the acceptance cycle as cycle 0. `wb_en` is high for exactly one cycle: cycle 2 when a source NaN decides the value, cycle 3 otherwise. `cu_fault` and `fmt_err` appear in cycle 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Block idle, operation will be taken |
| op_fmt | input | 2 | Format code (00 single, 01 double, others illegal) |
| src_used | input | NUM_SRC | Per-source use mask |
| src_ops | input | NUM_SRC*XLEN | Source operands, source i at bits i*XLEN upward |
| op_result | input | XLEN | Result computed by the arithmetic |
| fp_enable | input | 1 | FP unit enabled |
| fcsr_in | input | CSR_W | Current FCSR |
| dst_value | output | XLEN | Value to write to the destination |
| wb_en | output | 1 | Destination and FCSR write strobe |
| fcsr_out | output | CSR_W | Updated FCSR |
| cu_fault | output | 1 | Coprocessor-unusable fault strobe |
| cu_unit | output | 2 | Unit number carried by the fault |
| fmt_err | output | 1 | Illegal-format strobe |

## Verification
Each result has a fixed cycle, counted from the acceptance cycle. The cleared cause field is due in cycle 1. A fault or format error is due in cycle 1. A write decided by a source NaN is due in cycle 2, and any other write in cycle 3. The bench drives and samples on the falling edge. After acceptance it counts falling edges until the first event strobe, then compares both the event kind and that count with the expected latency before checking the value and the FCSR. It also checks the FCSR in cycle 1, and it checks that the block is idle with no write strobe on the cycle after each event.

// File: rtl/fpnan_pkg.sv
package fpnan_pkg;

    localparam int XLEN_DEF   = 64;
    localparam int CSR_W_DEF  = 32;

    localparam int CAUSE_LSB  = 12;
    localparam int CAUSE_MSB  = 17;
    localparam int INV_CAUSE  = 16;
    localparam int INV_FLAG   = 6;

    localparam int SGL_EXP_HI = 30;
    localparam int SGL_EXP_LO = 23;
    localparam int SGL_FR_HI  = 22;
    localparam int DBL_EXP_HI = 62;
    localparam int DBL_EXP_LO = 52;
    localparam int DBL_FR_HI  = 51;

    localparam logic [63:0] QNAN_SGL = 64'h0000_0000_7FBF_FFFF;
    localparam logic [63:0] QNAN_DBL = 64'h7FF7_FFFF_FFFF_FFFF;

    typedef enum logic [1:0] {
        FMT_SGL  = 2'b00,
        FMT_DBL  = 2'b01,
        FMT_RSV2 = 2'b10,
        FMT_RSV3 = 2'b11
    } fmt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCREEN,
        ST_RESCHK,
        ST_WRITE,
        ST_FAULT,
        ST_BADW
    } st_e;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
    } nan_cls_t;

endpackage

// File: rtl/fpnan_classify.sv
module fpnan_classify
    import fpnan_pkg::*;
#(
    parameter int XLEN = XLEN_DEF
) (
    input  logic [XLEN-1:0] val,
    input  logic            dbl,
    output nan_cls_t        cls
);

    logic exp_ones;
    logic frac_nz;
    logic frac_msb;
    logic unused_sign;

    assign unused_sign = val[XLEN-1];

    always_comb begin
        if (dbl) begin
            exp_ones = &val[DBL_EXP_HI:DBL_EXP_LO];
            frac_nz  = |val[DBL_FR_HI:0];
            frac_msb = val[DBL_FR_HI];
        end else begin
            exp_ones = &val[SGL_EXP_HI:SGL_EXP_LO];
            frac_nz  = |val[SGL_FR_HI:0];
            frac_msb = val[SGL_FR_HI];
        end
        cls.is_nan  = exp_ones & frac_nz;
        cls.is_snan = exp_ones & frac_nz & frac_msb;
    end

endmodule

// File: rtl/fpnan_pick.sv
module fpnan_pick
    import fpnan_pkg::*;
#(
    parameter int NUM_SRC = 2,
    parameter int XLEN    = XLEN_DEF
) (
    input  logic [NUM_SRC*XLEN-1:0] srcs,
    input  logic [NUM_SRC-1:0]      used,
    input  logic                    dbl,
    output logic                    any_nan,
    output logic [XLEN-1:0]         pick_val
);

    localparam int NARROW = 32;

    nan_cls_t        cls_v [NUM_SRC];
    logic [XLEN-1:0] qdef;

    assign qdef = dbl ? XLEN'(QNAN_DBL) : XLEN'(QNAN_SGL);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cls
        fpnan_classify #(.XLEN(XLEN)) u_cls (
            .val (srcs[i*XLEN +: XLEN]),
            .dbl (dbl),
            .cls (cls_v[i])
        );
    end

    // Walk from the highest index down so the lowest NaN source wins.
    always_comb begin
        any_nan  = 1'b0;
        pick_val = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (used[i] && cls_v[i].is_nan) begin
                any_nan = 1'b1;
                if (cls_v[i].is_snan) begin
                    pick_val = qdef;
                end else if (dbl) begin
                    pick_val = srcs[i*XLEN +: XLEN];
                end else begin
                    pick_val = {{(XLEN-NARROW){1'b0}}, srcs[i*XLEN +: NARROW]};
                end
            end
        end
    end

endmodule

// File: rtl/fpnan_csr_edit.sv
module fpnan_csr_edit
    import fpnan_pkg::*;
#(
    parameter int CSR_W = CSR_W_DEF
) (
    input  logic [CSR_W-1:0] csr_new,
    input  logic [CSR_W-1:0] csr_cur,
    output logic [CSR_W-1:0] csr_cleared,
    output logic [CSR_W-1:0] csr_invalid
);

    logic [CSR_W-1:0] cause_mask;
    logic [CSR_W-1:0] inv_bits;

    always_comb begin
        cause_mask = '0;
        for (int b = CAUSE_LSB; b <= CAUSE_MSB; b++) begin
            cause_mask[b] = 1'b1;
        end
        inv_bits            = '0;
        inv_bits[INV_CAUSE] = 1'b1;
        inv_bits[INV_FLAG]  = 1'b1;
        csr_cleared = csr_new & ~cause_mask;
        csr_invalid = csr_cur | inv_bits;
    end

endmodule

// File: rtl/fpnan_wb_gate.sv
module fpnan_wb_gate
    import fpnan_pkg::*;
#(
    parameter int NUM_SRC = 2,
    parameter int XLEN    = XLEN_DEF,
    parameter int CSR_W   = CSR_W_DEF,
    parameter int CU_UNIT = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    op_valid,
    output logic                    op_ready,
    input  logic [1:0]              op_fmt,
    input  logic [NUM_SRC-1:0]      src_used,
    input  logic [NUM_SRC*XLEN-1:0] src_ops,
    input  logic [XLEN-1:0]         op_result,
    input  logic                    fp_enable,
    input  logic [CSR_W-1:0]        fcsr_in,
    output logic [XLEN-1:0]         dst_value,
    output logic                    wb_en,
    output logic [CSR_W-1:0]        fcsr_out,
    output logic                    cu_fault,
    output logic [1:0]              cu_unit,
    output logic                    fmt_err
);

    localparam int NARROW = 32;

    st_e                     state;
    st_e                     nxt;
    fmt_e                    fmt_q;
    logic [NUM_SRC-1:0]      used_q;
    logic [NUM_SRC*XLEN-1:0] srcs_q;
    logic [XLEN-1:0]         res_q;
    logic [XLEN-1:0]         dst_q;
    logic [CSR_W-1:0]        fcsr_q;

    logic                    accept;
    logic                    dbl_q;
    logic                    src_nan;
    logic [XLEN-1:0]         src_pick;
    nan_cls_t                res_cls;
    logic [CSR_W-1:0]        csr_clr;
    logic [CSR_W-1:0]        csr_inv;
    logic [XLEN-1:0]         qdef_q;
    logic                    fmt_illegal;

    assign accept      = op_valid && op_ready;
    assign dbl_q       = (fmt_q == FMT_DBL);
    assign qdef_q      = dbl_q ? XLEN'(QNAN_DBL) : XLEN'(QNAN_SGL);
    assign fmt_illegal = (op_fmt != FMT_SGL) && (op_fmt != FMT_DBL);

    fpnan_pick #(.NUM_SRC(NUM_SRC), .XLEN(XLEN)) u_pick (
        .srcs     (srcs_q),
        .used     (used_q),
        .dbl      (dbl_q),
        .any_nan  (src_nan),
        .pick_val (src_pick)
    );

    fpnan_classify #(.XLEN(XLEN)) u_res_cls (
        .val (res_q),
        .dbl (dbl_q),
        .cls (res_cls)
    );

    fpnan_csr_edit #(.CSR_W(CSR_W)) u_csr (
        .csr_new     (fcsr_in),
        .csr_cur     (fcsr_q),
        .csr_cleared (csr_clr),
        .csr_invalid (csr_inv)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (op_valid) begin
                    if (!fp_enable)       nxt = ST_FAULT;
                    else if (fmt_illegal) nxt = ST_BADW;
                    else                  nxt = ST_SCREEN;
                end
            end
            ST_SCREEN: nxt = src_nan ? ST_WRITE : ST_RESCHK;
            ST_RESCHK: nxt = ST_WRITE;
            ST_WRITE:  nxt = ST_IDLE;
            ST_FAULT:  nxt = ST_IDLE;
            ST_BADW:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        op_ready = (state == ST_IDLE);
        wb_en    = (state == ST_WRITE);
        cu_fault = (state == ST_FAULT);
        fmt_err  = (state == ST_BADW);
        cu_unit  = (state == ST_FAULT) ? 2'(CU_UNIT) : 2'd0;
    end

    // Operand capture and destination/FCSR datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q  <= FMT_SGL;
            used_q <= '0;
            srcs_q <= '0;
            res_q  <= '0;
            dst_q  <= '0;
            fcsr_q <= '0;
        end else begin
            if (accept) begin
                fmt_q  <= fmt_e'(op_fmt);
                used_q <= src_used;
                srcs_q <= src_ops;
                res_q  <= op_result;
                fcsr_q <= csr_clr;
            end
            if (state == ST_SCREEN && src_nan) begin
                dst_q <= src_pick;
            end
            if (state == ST_RESCHK) begin
                if (res_cls.is_nan) begin
                    dst_q  <= qdef_q;
                    fcsr_q <= csr_inv;
                end else if (dbl_q) begin
                    dst_q <= res_q;
                end else begin
                    dst_q <= {{(XLEN-NARROW){1'b0}}, res_q[NARROW-1:0]};
                end
            end
        end
    end

    assign dst_value = dst_q;
    assign fcsr_out  = fcsr_q;

    AST_CAUSE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (fcsr_out[CAUSE_MSB:CAUSE_LSB] == '0)); // R2
    AST_HIGH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (fcsr_out[CSR_W-1:CAUSE_MSB+1] == $past(fcsr_in[CSR_W-1:CAUSE_MSB+1]))); // R2
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !op_ready); // R1
    AST_INVALID_QNAN: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && fcsr_out[INV_CAUSE]) |-> (dst_value == qdef_q)); // R7
    AST_FAULT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        cu_fault |-> (!wb_en && cu_unit == 2'(CU_UNIT))); // R9
    AST_EVENT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_en, cu_fault, fmt_err})); // R10
    AST_WB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> !wb_en); // R11

endmodule

// File: tb/test_fpnan_wb_gate.sv
module test_fpnan_wb_gate;
    import fpnan_pkg::*;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         op_valid;
    logic         op_ready;
    logic [1:0]   op_fmt;
    logic [1:0]   src_used;
    logic [127:0] src_ops;
    logic [63:0]  op_result;
    logic         fp_enable;
    logic [31:0]  fcsr_in;
    logic [63:0]  dst_value;
    logic         wb_en;
    logic [31:0]  fcsr_out;
    logic         cu_fault;
    logic [1:0]   cu_unit;
    logic         fmt_err;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    fpnan_wb_gate i_fpnan_wb_gate (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_fmt(op_fmt), .src_used(src_used), .src_ops(src_ops),
        .op_result(op_result), .fp_enable(fp_enable), .fcsr_in(fcsr_in),
        .dst_value(dst_value), .wb_en(wb_en), .fcsr_out(fcsr_out),
        .cu_fault(cu_fault), .cu_unit(cu_unit), .fmt_err(fmt_err)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // class: 0 zero, 1 normal, 2 infinity, 3 quiet NaN, 4 signalling NaN
    function automatic logic [63:0] make_val(input bit dbl, input int cls, input int salt);
        logic [63:0] s;
        logic [31:0] lo;
        s = 64'(salt);
        if (dbl) begin
            case (cls)
                0:       return s[0] ? 64'h8000_0000_0000_0000 : 64'h0;
                1:       return 64'h3FF0_0000_0000_0000 + s;
                2:       return 64'h7FF0_0000_0000_0000 | {s[0], 63'h0};
                3:       return 64'h7FF0_0000_0000_0000 | ((s & 64'hFFFF) + 64'h1);
                default: return 64'h7FF8_0000_0000_0000 | (s & 64'hFFFF);
            endcase
        end else begin
            case (cls)
                0:       lo = s[0] ? 32'h8000_0000 : 32'h0;
                1:       lo = 32'h3F80_0000 + s[31:0];
                2:       lo = 32'h7F80_0000 | {s[0], 31'h0};
                3:       lo = 32'h7F80_0000 | ((s[31:0] & 32'h1F_FFFF) + 32'h1);
                default: lo = 32'h7FC0_0000 | (s[31:0] & 32'h3F_FFFF);
            endcase
            return {32'hA5A5_5A5A, lo};
        end
    endfunction

    function automatic logic [63:0] qdef(input bit dbl);
        return dbl ? 64'h7FF7_FFFF_FFFF_FFFF : 64'h0000_0000_7FBF_FFFF;
    endfunction

    function automatic logic [63:0] fwd(input bit dbl, input logic [63:0] v);
        return dbl ? v : {32'h0, v[31:0]};
    endfunction

    // kind: 0 write, 1 fault, 2 format error
    task automatic run_op(input logic [1:0] fmt, input bit en, input logic [1:0] used,
                          input int ca, input int cb, input int cr, input int salt,
                          input logic [31:0] fcsr, input bit poke);
        bit          dbl;
        logic [63:0] a, b, r, exp_dst;
        logic [31:0] clr, exp_fcsr;
        int          exp_kind, exp_lat, lat, kind;
        bit          s0, s1;
        dbl = (fmt == 2'b01);
        a = make_val(dbl, ca, salt);
        b = make_val(dbl, cb, salt + 7);
        r = make_val(dbl, cr, salt + 13);
        clr = fcsr & ~32'h0003_F000;
        exp_fcsr = clr;
        exp_dst = 64'h0;
        s0 = used[0] && ca >= 3;
        s1 = used[1] && cb >= 3;
        if (!en) begin
            exp_kind = 1; exp_lat = 1;
        end else if (fmt[1]) begin
            exp_kind = 2; exp_lat = 1;
        end else if (s0 || s1) begin
            exp_kind = 0; exp_lat = 2;
            if (s0) exp_dst = (ca == 4) ? qdef(dbl) : fwd(dbl, a);
            else    exp_dst = (cb == 4) ? qdef(dbl) : fwd(dbl, b);
        end else begin
            exp_kind = 0; exp_lat = 3;
            if (cr >= 3) begin
                exp_dst = qdef(dbl);
                exp_fcsr = clr | 32'h0001_0040;
            end else begin
                exp_dst = fwd(dbl, r);
            end
        end

        @(negedge clk);
        chk(op_ready && !wb_en, "R1/R11 idle before op", {62'h0, op_ready, wb_en}, 64'h2);
        op_valid = 1'b1; op_fmt = fmt; fp_enable = en; src_used = used;
        src_ops = {b, a}; op_result = r; fcsr_in = fcsr;
        @(negedge clk);
        op_valid = 1'b0;
        if (poke) begin
            op_valid = 1'b1; op_fmt = 2'b01; fp_enable = 1'b0; fcsr_in = 32'hFFFF_FFFF;
        end
        lat = 1;
        chk(fcsr_out == clr, "R2 cause cleared", 64'(fcsr_out), 64'(clr));
        chk(!op_ready, "R1 busy after accept", 64'(op_ready), 64'h0);
        while (!(wb_en || cu_fault || fmt_err) && lat < 8) begin
            @(negedge clk);
            op_valid = 1'b0;
            lat++;
        end
        op_valid = 1'b0;
        kind = wb_en ? 0 : cu_fault ? 1 : fmt_err ? 2 : 3;
        chk(kind == exp_kind, (exp_kind == 1) ? "R9 event kind" : (exp_kind == 2) ? "R10 event kind" : "R11 event kind",
            64'(kind), 64'(exp_kind));
        chk(lat == exp_lat, "R11 latency", 64'(lat), 64'(exp_lat));
        if (exp_kind == 0) begin
            chk(dst_value == exp_dst,
                (s0 || s1) ? ((s0 ? ca : cb) == 4 ? "R4 sNaN source" : "R5/R6 qNaN source")
                           : (cr >= 3 ? "R7 NaN result" : "R8 plain result"),
                dst_value, exp_dst);
            chk(fcsr_out == exp_fcsr, (cr >= 3 && !(s0 || s1)) ? "R7 invalid bits" : "R8 fcsr kept",
                64'(fcsr_out), 64'(exp_fcsr));
        end else if (exp_kind == 1) begin
            chk(cu_unit == 2'd1, "R9 unit number", 64'(cu_unit), 64'h1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int op;
        rst_n = 1'b0; op_valid = 1'b0; op_fmt = 2'b00; src_used = 2'b00;
        src_ops = '0; op_result = '0; fp_enable = 1'b0; fcsr_in = '0;
        repeat (3) @(negedge clk);
        chk(op_ready && !wb_en && !cu_fault && !fmt_err, "R1 reset strobes",
            {60'h0, op_ready, wb_en, cu_fault, fmt_err}, 64'h8);
        chk(dst_value == 64'h0 && fcsr_out == 32'h0, "R1 reset values", dst_value | 64'(fcsr_out), 64'h0);
        rst_n = 1'b1;
        op = 0;
        // Sweep of formats, operand classes and use masks (R3..R8, R11)
        for (int d = 0; d < 2; d++) begin
            for (int ca = 0; ca < 5; ca++) begin
                for (int cb = 0; cb < 5; cb++) begin
                    for (int cr = 0; cr < 5; cr++) begin
                        for (int u = 0; u < 4; u++) begin
                            run_op(d[0] ? 2'b01 : 2'b00, 1'b1, u[1:0], ca, cb, cr, op * 3 + 1,
                                   32'hFFFF_FFFF ^ (32'(op) * 32'h9E37_79B1), (op % 7) == 0);
                            op++;
                        end
                    end
                end
            end
        end
        // Disabled unit (R9) and illegal formats (R10)
        for (int f = 0; f < 4; f++) begin
            run_op(f[1:0], 1'b0, 2'b11, 4, 3, 4, f, 32'hFFFF_FFFF, 1'b1);
            run_op(f[1:0], 1'b0, 2'b01, 1, 1, 1, f, 32'h0003_F000, 1'b0);
        end
        for (int f = 2; f < 4; f++) begin
            run_op(f[1:0], 1'b1, 2'b11, 4, 4, 4, f, 32'h1234_5678, 1'b1);
            run_op(f[1:0], 1'b1, 2'b00, 1, 1, 3, f, 32'hFFFF_FFFF, 1'b0);
        end
        @(negedge clk);
        chk(op_ready && !wb_en, "R1 final idle", {62'h0, op_ready, wb_en}, 64'h2);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule